// File: doc/BRIEF.md
# Configuration Stream Header Ratio Selector

This block sits beside a 32-bit configuration data stream and inspects its leading words as they go by on a valid/data interface. Software or a sequencer arms it with a start strobe and a width select. After that, every accepted word advances a word index. The word at index 69 carries an encryption indication. The word at index 229 carries an active-low compression indication. From these two flags and the width select, the block derives a two-bit clock-to-data ratio code. The data itself passes elsewhere untouched, because the block only observes it.

When the word at index 229 is accepted, the block issues a one-cycle done pulse and holds the ratio code stable until the next start. A stream-end strobe that arrives before the header is complete raises a one-cycle error pulse and drops the block back to idle. In that case no ratio is produced.

Top module: `hdr_ratio_sel`

## Requirements
- R1: After reset, ratio_o is 0, done_o is 0 and error_o is 0, and the block is idle.
- R2: The encryption flag is true when bits [3:2] of the word at zero-based index 69 are not both zero. The value 01, 10 or 11 in those bits means encrypted. Bits of any other word do not affect it.
- R3: The compression flag is taken from bit 1 of the word at index 229. A 0 in that bit means compressed, and a 1 means not compressed.
- R4: A stream that is neither encrypted nor compressed gives ratio code 0 (x1) at either width.
- R5: With width32_i low at start (16-bit width), an encrypted-only stream gives code 1 (x2), and any compressed stream gives code 2 (x4).
- R6: With width32_i high at start (32-bit width), an encrypted-only stream gives code 2 (x4), and any compressed stream gives code 3 (x8).
- R7: done_o is high for exactly one cycle, the cycle after the clock edge that accepts word 229, and ratio_o is valid from that cycle. ratio_o then holds until the next start_i, which clears it to 0.
- R8: A stream_end_i strobe seen while the header is incomplete gives a one-cycle error_o pulse in the following cycle, with no done_o, and returns the block to idle.
- R9: start_i clears the word index and the captured encryption flag. A start issued in the middle of a stream restarts counting from index 0.
- R10: The width select is sampled only in the start cycle. Later changes of width32_i do not alter the ratio of the current stream.
- R11: Once the header is complete, further words and stream-end strobes are ignored until the next start. There is no further done_o or error_o, and ratio_o holds.
- R12: Only cycles with word_valid_i high count as words. Words presented while idle (before any start, or after an error) are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Arms the block for a new stream and clears its state |
| width32_i | input | 1 | Width select sampled at start: 1 for 32-bit, 0 for 16-bit |
| word_valid_i | input | 1 | A stream word is present on word_data_i |
| word_data_i | input | 32 | Stream word |
| stream_end_i | input | 1 | Strobe marking the end of the stream |
| ratio_o | output | 2 | Ratio code: 0 x1, 1 x2, 2 x4, 3 x8 |
| done_o | output | 1 | One-cycle pulse when the header is complete |
| error_o | output | 1 | One-cycle pulse when the stream ends before the header is complete |

## Verification
The main function is exercised with all four combinations of the encryption and compression flags at both widths. The encrypted streams use each of the three non-zero codes in bits [3:2], so the two-bit field test is separated from a single-bit test. Filler words are all ones, so a design that reads the flags from the wrong index or the wrong bit gives a different ratio. Further patterns cover the following cases, each of which isolates one rule:
- valid gaps between words, which expose a counter that counts idle cycles;
- an early stream end;
- a restart in the middle of a stream with an encrypted header already captured, which exposes stale flags and a stale index;
- a width change after start;
- trailing traffic after done.

// File: rtl/hrs_pkg.sv
// Package: shared types and the ratio derivation for the header ratio selector.
// Assumes: ratio codes are a 2-bit log2 of the clock-to-data ratio.
package hrs_pkg;

    typedef enum logic [1:0] {
        RATIO_X1 = 2'd0,
        RATIO_X2 = 2'd1,
        RATIO_X4 = 2'd2,
        RATIO_X8 = 2'd3
    } ratio_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_HELD = 2'd2
    } phase_e;

    // Ratio for the given flags. The wide bus doubles any ratio above x1.
    function automatic ratio_e derive_ratio(input logic enc, input logic cmp,
                                            input logic wide);
        logic [1:0] code;
        if (cmp)      code = 2'd2;
        else if (enc) code = 2'd1;
        else          code = 2'd0;
        if (wide && (code != 2'd0)) code = code + 2'd1;
        return ratio_e'(code);
    endfunction

endpackage

// File: rtl/hrs_word_counter.sv
// Module: saturating word index for the stream header.
// Does: counts accepted words from 0 and stops at LAST_IDX. It flags the
//       two header positions that the capture logic needs.
// Assumes: MARK_IDX < LAST_IDX, and clear_i has priority over count_en_i.
module hrs_word_counter #(
    parameter int MARK_IDX = 69,
    parameter int LAST_IDX = 229,
    localparam int IDX_W   = $clog2(LAST_IDX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             count_en_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             at_mark_o,
    output logic             at_last_o
);

    localparam logic [IDX_W-1:0] MARK_V = IDX_W'(MARK_IDX);
    localparam logic [IDX_W-1:0] LAST_V = IDX_W'(LAST_IDX);

    logic [IDX_W-1:0] idx_q;

    // Advance the index on each accepted word and hold it at the last position.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            idx_q <= '0;
        end else if (count_en_i && (idx_q != LAST_V)) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign idx_o     = idx_q;
    assign at_mark_o = (idx_q == MARK_V);
    assign at_last_o = (idx_q == LAST_V);

    a_r12_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST_V);

    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (idx_q == '0));

    a_r12_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en_i && !clear_i && (idx_q != LAST_V)) |=>
            (idx_q == $past(idx_q) + IDX_W'(1)));

    a_r12_no_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en_i && !clear_i) |=> $stable(idx_q));

endmodule

// File: rtl/hrs_flag_capture.sv
// Module: header flag extraction.
// Does: latches the encryption flag from the marked word. It presents the
//       compression flag of the current word combinationally, so the final
//       decision can be taken on the accepting edge.
// Assumes: capture_i is high only for an accepted word at the marked index.
module hrs_flag_capture #(
    parameter int DATA_W  = 32,
    parameter int ENC_LSB = 2,
    parameter int ENC_MSB = 3,
    parameter int CMP_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              enc_o,
    output logic              cmp_o
);

    logic enc_q;

    // Latch the encryption indication from the marked word.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            enc_q <= 1'b0;
        end else if (capture_i) begin
            enc_q <= |data_i[ENC_MSB:ENC_LSB];
        end
    end

    assign enc_o = enc_q;
    // A low compression bit means the stream is compressed.
    assign cmp_o = ~data_i[CMP_BIT];

    wire unused_ok = &{1'b0, data_i};

    a_r2_enc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !capture_i) |=> $stable(enc_q));

    a_r9_enc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !enc_q);

endmodule

// File: rtl/hrs_ratio_encode.sv
// Module: ratio code derivation.
// Does: maps the encryption flag, the compression flag and the width to a
//       ratio code.
// Assumes: purely combinational, and the caller registers the result.
module hrs_ratio_encode
    import hrs_pkg::*;
(
    input  logic   enc_i,
    input  logic   cmp_i,
    input  logic   wide_i,
    output ratio_e ratio_o
);

    // Select the ratio from the flags and the width.
    always_comb begin
        ratio_o = derive_ratio(enc_i, cmp_i, wide_i);
    end

endmodule

// File: rtl/hdr_ratio_sel.sv
// Module: configuration stream header ratio selector (top).
// Does: arms on start_i, counts stream words, captures the header flags at
//       fixed indices and reports the ratio code with a done pulse. It
//       reports an early stream end with an error pulse.
// Assumes: one word per cycle at most, and start_i is not asserted while the
//          block is held in reset.
module hdr_ratio_sel
    import hrs_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ENC_IDX  = 69,
    parameter int CMP_IDX  = 229,
    parameter int ENC_LSB  = 2,
    parameter int ENC_MSB  = 3,
    parameter int CMP_BIT  = 1,
    localparam int IDX_W   = $clog2(CMP_IDX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              width32_i,
    input  logic              word_valid_i,
    input  logic [DATA_W-1:0] word_data_i,
    input  logic              stream_end_i,
    output logic [1:0]        ratio_o,
    output logic              done_o,
    output logic              error_o
);

    phase_e           phase_q;
    logic             wide_q;
    ratio_e           ratio_q;
    logic             done_q;
    logic             err_q;

    logic             count_en;
    logic [IDX_W-1:0] idx;
    logic             at_mark;
    logic             at_last;
    logic             enc_flag;
    logic             cmp_flag;
    ratio_e           ratio_next;
    logic             hdr_accept;

    // Words count only while the header is being collected and no restart is pending.
    assign count_en   = word_valid_i && (phase_q == PH_HDR) && !start_i;
    assign hdr_accept = count_en && at_last;

    hrs_word_counter #(
        .MARK_IDX (ENC_IDX),
        .LAST_IDX (CMP_IDX)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .count_en_i (count_en),
        .idx_o      (idx),
        .at_mark_o  (at_mark),
        .at_last_o  (at_last)
    );

    hrs_flag_capture #(
        .DATA_W  (DATA_W),
        .ENC_LSB (ENC_LSB),
        .ENC_MSB (ENC_MSB),
        .CMP_BIT (CMP_BIT)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .capture_i (count_en && at_mark),
        .data_i    (word_data_i),
        .enc_o     (enc_flag),
        .cmp_o     (cmp_flag)
    );

    hrs_ratio_encode u_enc (
        .enc_i   (enc_flag),
        .cmp_i   (cmp_flag),
        .wide_i  (wide_q),
        .ratio_o (ratio_next)
    );

    wire unused_idx = &{1'b0, idx};

    // Sequence the phases and register the ratio, done and error outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            wide_q  <= 1'b0;
            ratio_q <= RATIO_X1;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (start_i) begin
                phase_q <= PH_HDR;
                wide_q  <= width32_i;
                ratio_q <= RATIO_X1;
            end else begin
                case (phase_q)
                    PH_HDR: begin
                        if (hdr_accept) begin
                            phase_q <= PH_HELD;
                            ratio_q <= ratio_next;
                            done_q  <= 1'b1;
                        end else if (stream_end_i) begin
                            phase_q <= PH_IDLE;
                            err_q   <= 1'b1;
                        end
                    end
                    default: begin
                        phase_q <= phase_q;
                    end
                endcase
            end
        end
    end

    assign ratio_o = ratio_q;
    assign done_o  = done_q;
    assign error_o = err_q;

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));

    a_r8_err_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && !$past(start_i)) |-> (phase_q == PH_IDLE));

    a_r7_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$past(start_i)) |-> $stable(ratio_o));

    a_r6_wide_no_x2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && wide_q) |-> (ratio_o != RATIO_X2));

    a_r5_narrow_no_x8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !wide_q) |-> (ratio_o != RATIO_X8));

    a_r11_held_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_HELD) && !start_i) |=> (!done_o && !error_o));

endmodule

// File: tb/hdr_ratio_sel_test.sv
// Directed bench for the header ratio selector. Inputs change and outputs
// are sampled on the falling edge.
module hdr_ratio_sel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        width32_i = 1'b0;
    logic        word_valid_i = 1'b0;
    logic [31:0] word_data_i = '0;
    logic        stream_end_i = 1'b0;
    logic [1:0]  ratio_o;
    logic        done_o;
    logic        error_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    // Observations recorded by feed().
    int         done_seen_after;
    int         done_pulses;
    int         err_pulses;
    logic [1:0] ratio_at_done;

    always #10 clk = ~clk;

    hdr_ratio_sel uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .width32_i    (width32_i),
        .word_valid_i (word_valid_i),
        .word_data_i  (word_data_i),
        .stream_end_i (stream_end_i),
        .ratio_o      (ratio_o),
        .done_o       (done_o),
        .error_o      (error_o)
    );

    task automatic check(input string req, input string what,
                         input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    function automatic int exp_ratio(input bit w32, input bit enc, input bit cmp);
        int r;
        if (cmp)      r = 2;
        else if (enc) r = 1;
        else          r = 0;
        if (w32 && r != 0) r = r + 1;
        return r;
    endfunction

    // Records any pulse of done_o or error_o at the current sample point.
    task automatic observe(input int idx);
        if (done_o) begin
            done_pulses++;
            if (done_seen_after < 0) begin
                done_seen_after = idx;
                ratio_at_done   = ratio_o;
            end
        end
        if (error_o) err_pulses++;
    endtask

    task automatic clear_obs();
        done_seen_after = -1;
        done_pulses     = 0;
        err_pulses      = 0;
        ratio_at_done   = 2'd0;
    endtask

    task automatic do_start(input bit w32);
        start_i   = 1'b1;
        width32_i = w32;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Sends words first..last. Word 69 and word 229 come from the arguments,
    // and all other words are all ones.
    task automatic feed(input int first, input int last, input logic [31:0] w69,
                        input logic [31:0] w229, input int gap);
        for (int i = first; i <= last; i++) begin
            word_valid_i = 1'b1;
            word_data_i  = (i == 69) ? w69 : (i == 229) ? w229 : 32'hFFFF_FFFF;
            @(negedge clk);
            word_valid_i = 1'b0;
            word_data_i  = '0;
            observe(i);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                observe(i);
            end
        end
    endtask

    task automatic t_reset();
        check("R1", "ratio after reset", ratio_o, 0);
        check("R1", "done after reset", done_o, 0);
        check("R1", "error after reset", error_o, 0);
    endtask

    // One full header with the given flags. encbits are bits [3:2] of word 69.
    task automatic t_full(input bit w32, input logic [1:0] encbits, input bit cmp,
                          input string req);
        logic [31:0] w69;
        logic [31:0] w229;
        int          exp;
        w69  = {28'hFFFFFFF, encbits, 2'b11};
        w229 = cmp ? 32'hFFFF_FFFD : 32'hFFFF_FFFF;
        exp  = exp_ratio(w32, encbits != 2'b00, cmp);
        clear_obs();
        do_start(w32);
        check("R9", "ratio cleared by start", ratio_o, 0);
        feed(0, 229, w69, w229, 0);
        check("R7", "done after word 229", done_seen_after, 229);
        check(req, "ratio code", ratio_at_done, exp);
        @(negedge clk);
        observe(230);
        check("R7", "single done pulse", done_pulses, 1);
        check("R7", "ratio held", ratio_o, exp);
        check("R8", "no error on full header", err_pulses, 0);
    endtask

    task automatic t_short();
        clear_obs();
        do_start(1'b0);
        feed(0, 99, 32'hFFFF_FFFF, 32'hFFFF_FFFD, 0);
        stream_end_i = 1'b1;
        @(negedge clk);
        stream_end_i = 1'b0;
        check("R8", "error pulse after early end", error_o, 1);
        check("R8", "no done with error", done_o, 0);
        @(negedge clk);
        check("R8", "error lasts one cycle", error_o, 0);
        clear_obs();
        feed(0, 229, 32'hFFFF_FFFF, 32'hFFFF_FFFD, 0);
        check("R12", "idle words give no done", done_pulses, 0);
        check("R12", "ratio stays zero in idle", ratio_o, 0);
    endtask

    task automatic t_restart();
        clear_obs();
        do_start(1'b1);
        feed(0, 149, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        do_start(1'b0);
        feed(0, 229, 32'hFFFF_FFF3, 32'hFFFF_FFFF, 0);
        check("R9", "restart counts from zero", done_seen_after, 229);
        check("R9", "restart clears encryption flag", ratio_at_done, 0);
    endtask

    task automatic t_width_change();
        clear_obs();
        do_start(1'b0);
        width32_i = 1'b1;
        feed(0, 229, 32'hFFFF_FFF7, 32'hFFFF_FFFF, 0);
        width32_i = 1'b0;
        check("R10", "width change after start ignored", ratio_at_done, 1);
    endtask

    task automatic t_after_done();
        clear_obs();
        do_start(1'b1);
        feed(0, 229, 32'hFFFF_FFFB, 32'hFFFF_FFFF, 0);
        clear_obs();
        feed(230, 249, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        stream_end_i = 1'b1;
        @(negedge clk);
        stream_end_i = 1'b0;
        observe(250);
        @(negedge clk);
        observe(251);
        check("R11", "no done after header", done_pulses, 0);
        check("R11", "no error after header", err_pulses, 0);
        check("R11", "ratio held after trailing words", ratio_o, 2);
    endtask

    task automatic t_gaps();
        clear_obs();
        do_start(1'b0);
        feed(0, 229, 32'hFFFF_FFFF, 32'hFFFF_FFFD, 2);
        check("R12", "gaps do not count", done_pulses, 1);
        check("R12", "done seen at word 229", done_seen_after, 229);
        check("R3", "compressed narrow with gaps", ratio_at_done, 2);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full(1'b0, 2'b00, 1'b0, "R4");
        t_full(1'b1, 2'b00, 1'b0, "R4");
        t_full(1'b0, 2'b01, 1'b0, "R5");
        t_full(1'b0, 2'b10, 1'b1, "R5");
        t_full(1'b0, 2'b00, 1'b1, "R3");
        t_full(1'b1, 2'b10, 1'b0, "R6");
        t_full(1'b1, 2'b11, 1'b1, "R6");
        t_full(1'b1, 2'b00, 1'b1, "R6");
        t_full(1'b1, 2'b11, 1'b0, "R2");
        t_short();
        t_restart();
        t_width_change();
        t_after_done();
        t_gaps();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule